// File: doc/BRIEF.md
# Byte-coded DMA channel sequencer

This block runs one DMA channel from a short program of variable-length byte instructions. Those bytes sit in a program memory that is read one byte per cycle. The sequencer holds a source address, a destination address, a channel-control word, two 8-bit loop counters, a program counter and a 4-bit status code. Each word that is loaded from memory lands in a one-word data buffer. A store then writes that buffer out through a request/acknowledge memory port.

A store is posted: the channel goes on fetching while the write waits for its acknowledge. A write barrier, or the end of the program, waits for any such store to finish. An opcode the sequencer does not know stops the channel with an undefined-instruction fault. So does a bad register selector in a move. A memory error also stops the channel, with a fault that names the read or the write side.

The controller is one state machine:
- STOP: idle, status 0x0.
- FETCH: reads the opcode byte.
- OPND: collects the operand bytes.
- EXEC: carries out the instruction.
- LOAD: waits for a read acknowledge.
- BAR: barrier wait, status 0x5.
- COMPL: completing, status 0x9.
- FDRAIN: fault while a store is still pending, status 0xE.
- FAULT: status 0xF.

The transitions are:
- STOP→FETCH and FAULT→FETCH on start.
- FETCH→OPND for a multi-byte instruction, FETCH→EXEC for a one-byte instruction.
- OPND→EXEC on the last operand byte.
- EXEC→FETCH.
- EXEC→LOAD on a load, then LOAD→FETCH on the acknowledge.
- EXEC→BAR on a barrier with a store pending, then BAR→FETCH on the acknowledge.
- EXEC→COMPL on end with a store pending, then COMPL→STOP on the acknowledge.
- EXEC→STOP on end with no store pending.
- Any active state→FDRAIN or FAULT on a fault, then FDRAIN→FAULT on the acknowledge.

While any state other than STOP and FAULT is active, the status is 0x1.

Top module: `dma_bytecode_seq`

## Requirements
- R1: After reset the status is 0x0 (stopped), no memory request is raised, and the fault word is zero.
- R2: A start pulse loads the program counter from start_pc and begins fetching there. No-op (0x18) does nothing. End (0x00) returns the status to 0x0, leaving the program counter just past the end byte.
- R3: Move-immediate is 0xBC, then a selector byte, then a 32-bit value least significant byte first. Selector 0 writes the source address, 1 the channel-control word and 2 the destination address. Any other selector raises the undefined-instruction fault.
- R4: A load reads the word at the source address into the data buffer, and a store writes the buffer to the destination address. A request stays high, with a stable address and direction, until it is acknowledged.
- R5: Channel-control bit 0 makes the source address advance by 4 after each load. Bit 14 makes the destination address advance by 4 after each store. With a bit clear, its address does not change.
- R6: Loop start is 0x20 or 0x22: opcode bit 1 picks counter 0 or 1, and the second byte is loaded into that counter. Loop end is 0x38 or 0x3C: opcode bit 2 picks the counter, and the second byte is the distance back from the loop end to the first body byte. At a loop end, a nonzero counter is decremented and the jump is taken. A zero counter falls through. The body therefore runs count+1 times, and the two counters nest.
- R7: Load opcodes 0x04, 0x05, 0x07 and store opcodes 0x08, 0x09, 0x0B are accepted. Their bits 1:0 equal to 11 select the burst variant, which moves no data on this single-transfer channel. The values 00 and 01 transfer one word.
- R8: A store is posted. The next instructions execute while it is pending, but a later load or store does not start before its acknowledge.
- R9: The write barrier 0x13 holds the status at 0x5 while a store is pending, then resumes.
- R10: End with a store pending shows status 0x9 until the acknowledge, then 0x0.
- R11: Send-event (0x34) pulses evt_valid for one cycle. evt_num carries bits 7:3 of the second byte.
- R12: An unknown opcode sets fault bit 0 and status 0xF, and the program counter stays on the offending byte. A start pulse clears the fault word and restarts.
- R13: A read error sets fault bit 18 and a write error sets fault bit 17. A fault raised while a store is pending shows status 0xE until that store is acknowledged, then 0xF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, honoured when stopped or faulted |
| start_pc | input | PC_W | First program byte address |
| pm_addr | output | PC_W | Program memory byte address |
| pm_byte | input | 8 | Program byte at pm_addr, same cycle |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 32 | Write data from the data buffer |
| mem_ack | input | 1 | One-cycle acknowledge |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_err | input | 1 | Error flag, valid with mem_ack |
| evt_valid | output | 1 | Send-event pulse |
| evt_num | output | 5 | Event number |
| status | output | 4 | Channel status code |
| fault_type | output | 32 | Fault word |
| cur_pc | output | PC_W | Program counter |
| src_addr | output | AW | Source address register |
| dst_addr | output | AW | Destination address register |
| chan_ctrl | output | 32 | Channel-control register |

## Verification
The hardest situations to reach are the ones that only exist while a posted store is still pending: barrier wait, completing, and fault-drain. Reaching them also requires the channel to keep running ahead of its own write. The bench memory model can therefore withhold every acknowledge on request. The bench starts a program that stores and then reaches a barrier, an end, an event followed by a load, or an unknown opcode. It samples the status and the event record while the acknowledge is held, then releases it and checks the final state. Nested loops are checked by counting the writes the memory model receives.

// File: rtl/dseq_pkg.sv
package dseq_pkg;

    typedef enum logic [3:0] {
        S_STOP, S_FETCH, S_OPND, S_EXEC, S_LOAD,
        S_BAR, S_COMPL, S_FDRAIN, S_FAULT
    } seq_state_e;

    localparam logic [3:0] ST_STOPPED  = 4'h0;
    localparam logic [3:0] ST_RUNNING  = 4'h1;
    localparam logic [3:0] ST_BARRIER  = 4'h5;
    localparam logic [3:0] ST_COMPLETE = 4'h9;
    localparam logic [3:0] ST_FLT_DONE = 4'hE;
    localparam logic [3:0] ST_FAULTED  = 4'hF;

    localparam int FB_UNDEF = 0;
    localparam int FB_WRERR = 17;
    localparam int FB_RDERR = 18;

    // Instruction length in bytes; 0 marks an unknown opcode.
    function automatic logic [2:0] op_len(input logic [7:0] b);
        case (b)
            8'h00, 8'h04, 8'h05, 8'h07, 8'h08, 8'h09, 8'h0B,
            8'h13, 8'h18:                            op_len = 3'd1;
            8'h20, 8'h22, 8'h34, 8'h38, 8'h3C:       op_len = 3'd2;
            8'hBC:                                   op_len = 3'd6;
            default:                                 op_len = 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/dseq_addr_reg.sv
module dseq_addr_reg #(
    parameter int AW   = 32,
    parameter int STEP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld,
    input  logic [AW-1:0] ld_val,
    input  logic          step,
    output logic [AW-1:0] q
);
    localparam logic [AW-1:0] INC = AW'(STEP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    q <= '0;
        else if (ld)   q <= ld_val;
        else if (step) q <= q + INC;
    end
endmodule

// File: rtl/dseq_loop_bank.sv
module dseq_loop_bank #(
    parameter int NUM = 2,
    parameter int CW  = 8,
    localparam int IW = (NUM > 1) ? $clog2(NUM) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld,
    input  logic          dec,
    input  logic [IW-1:0] idx,
    input  logic [CW-1:0] ld_val,
    output logic          sel_nz
);
    logic [CW-1:0] cnt [NUM];

    for (genvar g = 0; g < NUM; g++) begin : g_ctr
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          cnt[g] <= '0;
            else if (ld  && idx == IW'(g))       cnt[g] <= ld_val;
            else if (dec && idx == IW'(g))       cnt[g] <= cnt[g] - 1'b1;
        end
    end

    assign sel_nz = (cnt[idx] != '0);

    // R6: a counter is never decremented through zero
    a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        dec |=> (cnt[$past(idx)] != {CW{1'b1}}));
endmodule

// File: rtl/dma_bytecode_seq.sv
module dma_bytecode_seq
    import dseq_pkg::*;
#(
    parameter int PC_W  = 8,
    parameter int AW    = 32,
    parameter int NLOOP = 2,
    localparam int LIW  = (NLOOP > 1) ? $clog2(NLOOP) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [PC_W-1:0] start_pc,
    output logic [PC_W-1:0] pm_addr,
    input  logic [7:0]      pm_byte,
    output logic            mem_req,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [31:0]     mem_wdata,
    input  logic            mem_ack,
    input  logic [31:0]     mem_rdata,
    input  logic            mem_err,
    output logic            evt_valid,
    output logic [4:0]      evt_num,
    output logic [3:0]      status,
    output logic [31:0]     fault_type,
    output logic [PC_W-1:0] cur_pc,
    output logic [AW-1:0]   src_addr,
    output logic [AW-1:0]   dst_addr,
    output logic [31:0]     chan_ctrl
);
    seq_state_e state, nstate;

    logic [PC_W-1:0] pc, ipc;
    logic [7:0]      opc;
    logic [39:0]     arg;
    logic [2:0]      olen, oidx, flen;
    logic [31:0]     ccr, dbuf, ftype;
    logic [AW-1:0]   st_addr;
    logic            st_out;

    logic [1:0]      a_ld, a_step;
    logic [AW-1:0]   a_q [2];
    logic            lp_ld, lp_dec, lp_nz, jump, ccr_ld, issue_st, evt;
    logic            undef, rd_flt, st_ack, st_err, ld_go, ld_ack, pend;
    logic [LIW-1:0]  lp_idx;

    assign flen   = op_len(pm_byte);
    assign st_ack = st_out & mem_ack;
    assign st_err = st_ack & mem_err;
    assign pend   = st_out & ~st_ack;
    assign ld_go  = (state == S_LOAD) & ~st_out;
    assign ld_ack = ld_go & mem_ack;
    assign lp_idx = LIW'(opc[4] ? opc[2] : opc[1]);

    for (genvar k = 0; k < 2; k++) begin : g_addr
        dseq_addr_reg #(.AW(AW), .STEP(4)) u_areg (
            .clk(clk), .rst_n(rst_n), .ld(a_ld[k]), .ld_val(AW'(arg[39:8])),
            .step(a_step[k]), .q(a_q[k])
        );
    end

    dseq_loop_bank #(.NUM(NLOOP), .CW(8)) u_loops (
        .clk(clk), .rst_n(rst_n), .ld(lp_ld), .dec(lp_dec), .idx(lp_idx),
        .ld_val(arg[7:0]), .sel_nz(lp_nz)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_STOP;
        else        state <= nstate;
    end

    // Next state and control strobes
    always_comb begin
        nstate = state; a_ld = '0; a_step = '0; lp_ld = 1'b0; lp_dec = 1'b0;
        jump = 1'b0; ccr_ld = 1'b0; issue_st = 1'b0; evt = 1'b0;
        undef = 1'b0; rd_flt = 1'b0;
        unique case (state)
            S_STOP, S_FAULT: if (start) nstate = S_FETCH;
            S_FETCH: begin
                if (flen == 3'd0)      undef  = 1'b1;
                else if (flen == 3'd1) nstate = S_EXEC;
                else                   nstate = S_OPND;
            end
            S_OPND: if (oidx == olen - 3'd1) nstate = S_EXEC;
            S_EXEC: begin
                nstate = S_FETCH;
                case (opc)
                    8'h00: nstate = pend ? S_COMPL : S_STOP;
                    8'h13: if (pend) nstate = S_BAR;
                    8'h34: evt = 1'b1;
                    8'h20, 8'h22: lp_ld = 1'b1;
                    8'h38, 8'h3C: if (lp_nz) begin lp_dec = 1'b1; jump = 1'b1; end
                    8'hBC: begin
                        case (arg[7:0])
                            8'd0:    a_ld[0] = 1'b1;
                            8'd1:    ccr_ld  = 1'b1;
                            8'd2:    a_ld[1] = 1'b1;
                            default: undef   = 1'b1;
                        endcase
                    end
                    8'h04, 8'h05, 8'h07: if (opc[1:0] != 2'b11) nstate = S_LOAD;
                    8'h08, 8'h09, 8'h0B: begin
                        if (opc[1:0] != 2'b11) begin
                            if (pend) nstate = S_EXEC;
                            else begin issue_st = 1'b1; a_step[1] = ccr[14]; end
                        end
                    end
                    default: ;
                endcase
            end
            S_LOAD: if (ld_ack) begin
                a_step[0] = ccr[0];
                if (mem_err) rd_flt = 1'b1;
                else         nstate = S_FETCH;
            end
            S_BAR:    if (st_ack) nstate = S_FETCH;
            S_COMPL:  if (st_ack) nstate = S_STOP;
            S_FDRAIN: if (st_ack) nstate = S_FAULT;
        endcase
        if (st_err)               nstate = S_FAULT;
        else if (undef || rd_flt) nstate = pend ? S_FDRAIN : S_FAULT;
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc <= '0; ipc <= '0; opc <= '0; arg <= '0; olen <= '0; oidx <= '0;
            ccr <= '0; dbuf <= '0; ftype <= '0; st_addr <= '0; st_out <= 1'b0;
        end else begin
            if ((state == S_STOP || state == S_FAULT) && start) begin
                pc    <= start_pc;
                ftype <= '0;
            end
            if (state == S_FETCH) begin
                opc  <= pm_byte;
                ipc  <= pc;
                olen <= flen;
                oidx <= 3'd1;
                if (flen != 3'd0) pc <= pc + 1'b1;
            end
            if (state == S_OPND) begin
                arg[{3'(oidx - 3'd1), 3'b000} +: 8] <= pm_byte;
                oidx <= oidx + 3'd1;
                pc   <= pc + 1'b1;
            end
            if (jump)     pc      <= ipc - PC_W'(arg[7:0]);
            if (ccr_ld)   ccr     <= arg[39:8];
            if (ld_ack)   dbuf    <= mem_rdata;
            if (issue_st) st_addr <= a_q[1];
            if (issue_st)    st_out <= 1'b1;
            else if (st_ack) st_out <= 1'b0;
            if (undef)  ftype[FB_UNDEF] <= 1'b1;
            if (rd_flt) ftype[FB_RDERR] <= 1'b1;
            if (st_err) ftype[FB_WRERR] <= 1'b1;
        end
    end

    // Outputs
    always_comb begin
        unique case (state)
            S_STOP:   status = ST_STOPPED;
            S_BAR:    status = ST_BARRIER;
            S_COMPL:  status = ST_COMPLETE;
            S_FDRAIN: status = ST_FLT_DONE;
            S_FAULT:  status = ST_FAULTED;
            default:  status = ST_RUNNING;
        endcase
        pm_addr    = pc;
        cur_pc     = pc;
        mem_req    = st_out | ld_go;
        mem_we     = st_out;
        mem_addr   = st_out ? st_addr : a_q[0];
        mem_wdata  = dbuf;
        evt_valid  = evt;
        evt_num    = arg[7:3];
        fault_type = ftype;
        src_addr   = a_q[0];
        dst_addr   = a_q[1];
        chan_ctrl  = ccr;
    end

    // R4: an unacknowledged request holds its address and direction
    a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
    // R1: a stopped channel raises no request
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (status == ST_STOPPED) |-> !mem_req);
    // R9: barrier wait only while a write is pending
    a_r9_bar_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (status == ST_BARRIER) |-> (mem_req && mem_we));
    // R13: faulted status always carries a fault cause
    a_r13_fault_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (status == ST_FAULTED) |-> (fault_type != '0));
    // R10: completing status only while a write is pending
    a_r10_compl_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (status == ST_COMPLETE) |-> (mem_req && mem_we));
endmodule

// File: tb/dma_bytecode_seq_tb.sv
module dma_bytecode_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  start_pc = '0;
    logic [7:0]  pm_addr;
    logic [7:0]  pm_byte;
    logic        mem_req, mem_we, mem_ack = 1'b0, mem_err = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
    logic        evt_valid;
    logic [4:0]  evt_num;
    logic [3:0]  status;
    logic [31:0] fault_type, src_addr, dst_addr, chan_ctrl;
    logic [7:0]  cur_pc;

    logic [7:0]  prog [256];
    logic [31:0] dmem [64];
    logic [31:0] err_addr = 32'hFFFF_FFFF;
    logic        hold = 1'b0;
    int          wait_cnt = 0, ack_lat = 1;
    int          n_wr = 0, n_rd = 0, evt_cnt = 0;
    logic [4:0]  evt_last = '0;
    int          checks = 0, fails = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    assign pm_byte = prog[pm_addr];

    dma_bytecode_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_pc(start_pc),
        .pm_addr(pm_addr), .pm_byte(pm_byte), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .mem_err(mem_err), .evt_valid(evt_valid),
        .evt_num(evt_num), .status(status), .fault_type(fault_type),
        .cur_pc(cur_pc), .src_addr(src_addr), .dst_addr(dst_addr),
        .chan_ctrl(chan_ctrl)
    );

    // Memory responder, driven at the falling edge
    initial forever begin
        @(negedge clk);
        if (mem_req && !mem_ack && !hold) begin
            if (wait_cnt < ack_lat) wait_cnt++;
            else begin
                mem_ack = 1'b1;
                mem_err = (mem_addr == err_addr);
                mem_rdata = dmem[mem_addr[7:2]];
                if (mem_we) begin
                    dmem[mem_addr[7:2]] = mem_wdata;
                    n_wr++;
                end else n_rd++;
            end
        end else if (mem_ack) begin
            mem_ack = 1'b0; mem_err = 1'b0; wait_cnt = 0;
        end
    end

    initial forever begin
        @(negedge clk);
        if (evt_valid) begin evt_cnt++; evt_last = evt_num; end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic clear_all();
        for (int i = 0; i < 256; i++) prog[i] = 8'h00;
        for (int i = 0; i < 64; i++) dmem[i] = 32'hA000_0000 + 32'(i);
        err_addr = 32'hFFFF_FFFF; hold = 1'b0;
        n_wr = 0; n_rd = 0; evt_cnt = 0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic put(input int at, input logic [7:0] b);
        prog[at] = b;
    endtask

    task automatic go(input logic [7:0] pc0);
        @(negedge clk);
        start = 1'b1; start_pc = pc0;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 3000; i++) begin
            if (status == 4'h0 || status == 4'hF) break;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        clear_all();
        chk("R1 status", 32'(status), 32'h0);
        chk("R1 req", 32'(mem_req), 32'h0);
        chk("R1 fault", fault_type, 32'h0);
    endtask

    task automatic t_move();
        clear_all();
        put(0, 8'hBC); put(1, 8'h00); put(2, 8'h44); put(3, 8'h33); put(4, 8'h22); put(5, 8'h11);
        put(6, 8'hBC); put(7, 8'h01); put(8, 8'h01); put(9, 8'h40); put(10, 8'h00); put(11, 8'h00);
        put(12, 8'hBC); put(13, 8'h02); put(14, 8'h78); put(15, 8'h56); put(16, 8'h34); put(17, 8'h12);
        put(18, 8'h18); put(19, 8'h00);
        go(8'd0); wait_done();
        chk("R3 src", src_addr, 32'h1122_3344);
        chk("R3 ctrl", chan_ctrl, 32'h0000_4001);
        chk("R3 dst", dst_addr, 32'h1234_5678);
        chk("R2 stopped", 32'(status), 32'h0);
        chk("R2 pc", 32'(cur_pc), 32'd20);
    endtask

    task automatic t_copy();
        clear_all();
        put(0, 8'hBC); put(1, 8'h00);
        put(6, 8'hBC); put(7, 8'h01); put(8, 8'h01); put(9, 8'h40);
        put(12, 8'hBC); put(13, 8'h02); put(14, 8'h80);
        put(18, 8'h20); put(19, 8'h03);
        put(20, 8'h04); put(21, 8'h08);
        put(22, 8'h38); put(23, 8'h02);
        put(24, 8'h13); put(25, 8'h00);
        go(8'd0); wait_done();
        chk("R6 four passes", 32'(n_wr), 32'd4);
        chk("R4 copy word0", dmem[32], 32'hA000_0000);
        chk("R4 copy word3", dmem[35], 32'hA000_0003);
        chk("R5 src advanced", src_addr, 32'h10);
        chk("R5 dst advanced", dst_addr, 32'h90);
        chk("R2 stopped", 32'(status), 32'h0);
    endtask

    task automatic t_noinc();
        clear_all();
        put(0, 8'hBC); put(1, 8'h00); put(2, 8'h08);
        put(6, 8'hBC); put(7, 8'h02); put(8, 8'h40);
        put(12, 8'h20); put(13, 8'h02);
        put(14, 8'h05); put(15, 8'h09);
        put(16, 8'h38); put(17, 8'h02); put(18, 8'h00);
        go(8'd0); wait_done();
        chk("R5 src held", src_addr, 32'h08);
        chk("R5 dst held", dst_addr, 32'h40);
        chk("R6 three passes", 32'(n_wr), 32'd3);
        chk("R4 data", dmem[16], 32'hA000_0002);
    endtask

    task automatic t_nested();
        clear_all();
        put(0, 8'h22); put(1, 8'h02);
        put(2, 8'h20); put(3, 8'h01);
        put(4, 8'h08);
        put(5, 8'h38); put(6, 8'h01);
        put(7, 8'h3C); put(8, 8'h05);
        put(9, 8'h00);
        go(8'd0); wait_done();
        chk("R6 nested stores", 32'(n_wr), 32'd6);
        chk("R6 end pc", 32'(cur_pc), 32'd10);
    endtask

    task automatic t_burst();
        clear_all();
        put(0, 8'h07); put(1, 8'h0B); put(2, 8'h05); put(3, 8'h09); put(4, 8'h00);
        go(8'd0); wait_done();
        chk("R7 reads", 32'(n_rd), 32'd1);
        chk("R7 writes", 32'(n_wr), 32'd1);
        chk("R7 stopped", 32'(status), 32'h0);
    endtask

    task automatic t_posted();
        clear_all();
        hold = 1'b1;
        put(0, 8'h08); put(1, 8'h34); put(2, 8'h18); put(3, 8'h04); put(4, 8'h00);
        go(8'd0);
        repeat (15) @(negedge clk);
        chk("R8 ran ahead event", 32'(evt_cnt), 32'd1);
        chk("R11 event number", 32'(evt_last), 32'd3);
        chk("R8 load waits", 32'(n_rd), 32'd0);
        chk("R8 still running", 32'(status), 32'h1);
        hold = 1'b0;
        wait_done();
        chk("R8 load after store", 32'(n_rd), 32'd1);
        chk("R11 single pulse", 32'(evt_cnt), 32'd1);
    endtask

    task automatic t_barrier();
        clear_all();
        hold = 1'b1;
        put(0, 8'h08); put(1, 8'h13); put(2, 8'h00);
        go(8'd0);
        repeat (10) @(negedge clk);
        chk("R9 barrier wait", 32'(status), 32'h5);
        hold = 1'b0;
        wait_done();
        chk("R9 resumed", 32'(status), 32'h0);
        chk("R9 write", 32'(n_wr), 32'd1);
    endtask

    task automatic t_complete();
        clear_all();
        hold = 1'b1;
        put(0, 8'h08); put(1, 8'h00);
        go(8'd0);
        repeat (10) @(negedge clk);
        chk("R10 completing", 32'(status), 32'h9);
        hold = 1'b0;
        wait_done();
        chk("R10 stopped", 32'(status), 32'h0);
    endtask

    task automatic t_undef();
        clear_all();
        put(16, 8'h18); put(17, 8'hFF);
        go(8'd16); wait_done();
        chk("R12 faulted", 32'(status), 32'hF);
        chk("R12 undef bit", fault_type, 32'h1);
        chk("R12 pc held", 32'(cur_pc), 32'd17);
        put(40, 8'h00);
        go(8'd40); wait_done();
        chk("R12 restart clears", fault_type, 32'h0);
        chk("R12 restart stops", 32'(status), 32'h0);
        put(48, 8'hBC); put(49, 8'h03); put(54, 8'h00);
        go(8'd48); wait_done();
        chk("R3 bad selector", fault_type, 32'h1);
    endtask

    task automatic t_errors();
        clear_all();
        err_addr = 32'h40;
        put(0, 8'hBC); put(1, 8'h00); put(2, 8'h40); put(6, 8'h04); put(7, 8'h00);
        go(8'd0); wait_done();
        chk("R13 read error", fault_type, 32'h0004_0000);
        chk("R13 read fault status", 32'(status), 32'hF);
        clear_all();
        err_addr = 32'h80; hold = 1'b1;
        put(0, 8'hBC); put(1, 8'h02); put(2, 8'h80); put(6, 8'h08); put(7, 8'hFF);
        go(8'd0);
        repeat (15) @(negedge clk);
        chk("R13 fault drain", 32'(status), 32'hE);
        hold = 1'b0;
        wait_done();
        chk("R13 write error", fault_type, 32'h0002_0001);
        chk("R13 faulted", 32'(status), 32'hF);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_move();
        t_copy();
        t_noinc();
        t_nested();
        t_burst();
        t_posted();
        t_barrier();
        t_complete();
        t_undef();
        t_errors();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule